// File: doc/BRIEF.md
# Serial-Load Latched Display Driver Core

This block is the digital core of a chainable display driver. A serial bit stream enters a shift register, one bit for each clock edge on which the shift enable is high. Each stage of the register belongs to one output channel. A level-sensitive strobe makes a bank of holding stages transparent, so the channel pattern follows the register while the strobe is high. The pattern freezes when the strobe goes low.

Each channel drives two complementary enables: one for the high-side source and one for the active pull-down sink. A blanking input turns every source off and every sink on. It does not disturb the held pattern, so the display comes back unchanged when blanking is released. The last register stage is brought out as a registered serial output, so several devices can share one data line in a chain.

Top module: `serial_latched_driver`

## Requirements
- R1: A synchronous active-low reset (`rst_n` low at a rising `clk` edge) clears the shift register and the holding stages to 0. After that edge, with `blank` low, every `src_en` bit is 0, every `snk_en` bit is 1, and `sdo` is 0.
- R2: On a rising edge with `shift_en` high, stage 0 takes `sdi` and stage i takes the old stage i-1. With `shift_en` low, the register keeps its value.
- R3: `sdo` is the highest stage (stage W-1) of the shift register. It changes only at a rising clock edge.
- R4: After W shifts, the first bit shifted in sits in channel W-1, and the last bit shifted in sits in channel 0.
- R5: While `strobe` is high, the holding pattern equals the shift register in the same cycle, including content shifted in while the strobe stays high. The holding stages close with the register value seen at the last edge on which `strobe` was high.
- R6: While `strobe` is low, shifting does not change the holding pattern or the channel enables.
- R7: While `blank` is high, every `src_en` bit is 0 and every `snk_en` bit is 1, whatever the holding pattern is.
- R8: Blanking leaves the holding pattern unchanged. When `blank` returns low, the channels show the pattern that was held before.
- R9: With `blank` low, a held 1 in channel i gives `src_en[i]`=1 and `snk_en[i]`=0. A held 0 gives `src_en[i]`=0 and `snk_en[i]`=1.
- R10: No channel ever has `src_en` and `snk_en` both 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| shift_en | input | 1 | Enables one shift step on this edge |
| sdi | input | 1 | Serial data in |
| strobe | input | 1 | High: holding stages are transparent; low: they hold |
| blank | input | 1 | High: all sources off, all sinks on |
| src_en | output | W (12) | Per-channel source enable |
| snk_en | output | W (12) | Per-channel pull-down sink enable |
| sdo | output | 1 | Serial data out (stage W-1), for chaining |

## Verification
Shifting and transparent latching can occur in the same cycle. So can shifting and blanking. The bench holds `strobe` high while new bits are clocked in and expects the channel enables to track each shifted pattern in the very next cycle. It then repeats the shifting with `strobe` low and expects the channels to stay frozen. A third pass shifts with `blank` high and expects all sources off. Once `blank` is released, the held pattern must reappear bit for bit, and `sdo` must keep reporting the new stream at every step.

// File: rtl/sld_pkg.sv
// Package: shared width default and the per-channel drive pair type.
// Assumes: nothing; pure type and function definitions.
package sld_pkg;

    localparam int unsigned SLD_DEF_W = 12;

    // Two complementary controls for one output channel.
    typedef struct packed {
        logic src;
        logic snk;
    } drv_pair_t;

    // Map a held bit and the blanking level to the drive pair.
    function automatic drv_pair_t drive_of(input logic held, input logic blank_lv);
        drv_pair_t p;
        if (blank_lv) begin
            p.src = 1'b0;
            p.snk = 1'b1;
        end else begin
            p.src = held;
            p.snk = ~held;
        end
        return p;
    endfunction

endpackage

// File: rtl/sld_shift_chain.sv
// Module: sld_shift_chain
// Serial-in shift register of W stages, with the last stage brought out.
// Assumes: W >= 2; rst_n is synchronous and active low.
module sld_shift_chain #(
    parameter int unsigned W = sld_pkg::SLD_DEF_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         sdi,
    output logic [W-1:0] sr_q,
    output logic         sdo
);

    localparam int unsigned TOP = W - 1;

    // One flop per stage; stage 0 is fed from the serial input.
    for (genvar i = 0; i < W; i++) begin : g_stage
        logic d_in;
        if (i == 0) begin : g_head
            assign d_in = sdi;
        end else begin : g_body
            assign d_in = sr_q[i-1];
        end

        // Stage register: clear on reset, take the upstream bit when enabled.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sr_q[i] <= 1'b0;
            end else if (shift_en) begin
                sr_q[i] <= d_in;
            end
        end
    end

    assign sdo = sr_q[TOP];

    assert_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (sr_q == '0));

    assert_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (sr_q == {$past(sr_q[W-2:0]), $past(sdi)}));

    assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(sr_q));

    assert_sdo_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (sdo == $past(sr_q[W-2])));

endmodule

// File: rtl/sld_hold_bank.sv
// Module: sld_hold_bank
// Transparent holding stages. While strobe is high, the view passes the
// shift register straight through. The stored copy is refreshed on every
// edge seen with strobe high. While strobe is low, the view is the stored copy.
// Assumes: strobe is synchronous to clk; rst_n is synchronous, active low.
module sld_hold_bank #(
    parameter int unsigned W = sld_pkg::SLD_DEF_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         strobe,
    input  logic [W-1:0] sr_q,
    output logic [W-1:0] view
);

    logic [W-1:0] held_q;

    // Stored copy: cleared on reset, refreshed while the strobe is open.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= '0;
        end else if (strobe) begin
            held_q <= sr_q;
        end
    end

    // Transparent path while open, stored copy while closed.
    always_comb begin
        view = strobe ? sr_q : held_q;
    end

    assert_closed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> (strobe || $stable(view)));

    assert_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> (strobe || (view == $past(sr_q))));

endmodule

// File: rtl/sld_channel.sv
// Module: sld_channel
// Drive logic for one channel: maps a held bit and blanking onto the
// complementary source and sink enables.
// Assumes: clk and rst_n are used only by the guarding assertions.
module sld_channel (
    input  logic clk,
    input  logic rst_n,
    input  logic held,
    input  logic blank,
    output logic src,
    output logic snk
);

    import sld_pkg::*;

    drv_pair_t pair;

    // Decode the drive pair for this channel.
    always_comb begin
        pair = drive_of(held, blank);
    end

    assign src = pair.src;
    assign snk = pair.snk;

    assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(src && snk));

    assert_blanked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        blank |-> (!src && snk));

endmodule

// File: rtl/serial_latched_driver.sv
// Module: serial_latched_driver (top)
// Shift register -> transparent holding bank -> per-channel drive pairs.
// sdo is the registered last stage, so it can feed the next device in a chain.
// Assumes: all inputs are synchronous to clk; reset is synchronous, active low.
module serial_latched_driver #(
    parameter int unsigned W = sld_pkg::SLD_DEF_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         sdi,
    input  logic         strobe,
    input  logic         blank,
    output logic [W-1:0] src_en,
    output logic [W-1:0] snk_en,
    output logic         sdo
);

    logic [W-1:0] sr_q;
    logic [W-1:0] view;

    sld_shift_chain #(.W(W)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .sdi      (sdi),
        .sr_q     (sr_q),
        .sdo      (sdo)
    );

    sld_hold_bank #(.W(W)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (strobe),
        .sr_q   (sr_q),
        .view   (view)
    );

    // One drive pair per channel.
    for (genvar c = 0; c < W; c++) begin : g_ch
        sld_channel u_ch (
            .clk   (clk),
            .rst_n (rst_n),
            .held  (view[c]),
            .blank (blank),
            .src   (src_en[c]),
            .snk   (snk_en[c])
        );
    end

    assert_sdo_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(sdo));

endmodule

// File: tb/sim_serial_latched_driver.sv
module sim_serial_latched_driver;

    localparam int W     = 12;
    localparam int CLK_P = 10;

    typedef struct {
        logic [W-1:0] src;
        logic [W-1:0] snk;
        logic         sdo;
        string        tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic shift_en = 1'b0;
    logic sdi = 1'b0;
    logic strobe = 1'b0;
    logic blank = 1'b0;
    logic [W-1:0] src_en, snk_en;
    logic sdo;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    exp_t sb[$];

    // Reference state, updated from the requirements.
    logic [W-1:0] m_sr = '0;
    logic [W-1:0] m_hold = '0;
    logic p_rst = 1'b0, p_sh = 1'b0, p_d = 1'b0, p_st = 1'b0;

    serial_latched_driver #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .sdi(sdi),
        .strobe(strobe), .blank(blank),
        .src_en(src_en), .snk_en(snk_en), .sdo(sdo)
    );

    always #(CLK_P/2) clk = ~clk;

    // Driver: consume an edge, update the model, apply new inputs, push the expectation.
    task automatic cyc(input logic r, input logic sh, input logic d,
                       input logic st, input logic bl, input string tag);
        exp_t e;
        logic [W-1:0] lat;
        @(posedge clk);
        if (!p_rst) begin
            m_sr = '0;
            m_hold = '0;
        end else begin
            if (p_st) m_hold = m_sr;
            if (p_sh) m_sr = {m_sr[W-2:0], p_d};
        end
        #1;
        rst_n = r; shift_en = sh; sdi = d; strobe = st; blank = bl;
        p_rst = r; p_sh = sh; p_d = d; p_st = st;
        lat = st ? m_sr : m_hold;
        e.src = bl ? '0 : lat;
        e.snk = bl ? '1 : ~lat;
        e.sdo = m_sr[W-1];
        e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: pop one expectation per cycle and compare at the falling edge.
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_run++;
            if (src_en !== e.src || snk_en !== e.snk) begin
                n_fail++;
                $display("FAIL %s: src=%h snk=%h expected src=%h snk=%h",
                         e.tag, src_en, snk_en, e.src, e.snk);
            end
            n_run++;
            if (sdo !== e.sdo) begin
                n_fail++;
                $display("FAIL R3 sdo (%s): got %b expected %b", e.tag, sdo, e.sdo);
            end
            n_run++;
            if ((src_en & snk_en) !== '0) begin
                n_fail++;
                $display("FAIL R10 overlap: got %h expected 000", src_en & snk_en);
            end
        end
    end

    // Shift a word in, first bit = MSB, so the first bit lands in channel W-1 (R4).
    task automatic load_word(input logic [W-1:0] w, input logic st,
                             input logic bl, input string tag);
        for (int i = W - 1; i >= 0; i--) cyc(1, 1, w[i], st, bl, tag);
    endtask

    initial begin
        // R1: reset clears state; sources off, sinks on.
        cyc(0, 0, 0, 0, 0, "R1 reset");
        cyc(0, 1, 1, 0, 0, "R1 reset");
        cyc(1, 0, 0, 0, 0, "R1 after reset");
        // R6: shifting with strobe low leaves channels frozen at 0.
        load_word(12'hA5C, 0, 0, "R6 closed shift");
        // R2: shift enable low holds the register.
        cyc(1, 0, 1, 0, 0, "R2 hold");
        cyc(1, 0, 0, 0, 0, "R2 hold");
        // R5/R4: open strobe one cycle, then close; pattern A5C in place.
        cyc(1, 0, 0, 1, 0, "R5 open");
        cyc(1, 0, 0, 0, 0, "R4 first bit in top channel");
        cyc(1, 0, 0, 0, 0, "R9 held pattern");
        // R7: blank high while new data is shifted with strobe low.
        load_word(12'h3C6, 0, 1, "R7 blank");
        // R8: release blank, held A5C reappears.
        cyc(1, 0, 0, 0, 0, "R8 unblank");
        cyc(1, 0, 0, 0, 0, "R8 unblank");
        // R5: strobe held high while shifting, channels track every step.
        load_word(12'h5A1, 1, 0, "R5 transparent");
        cyc(1, 1, 1, 0, 0, "R5 closed after shift");
        cyc(1, 1, 0, 0, 0, "R6 closed");
        // R7 with strobe open: blanked regardless of the pattern.
        cyc(1, 1, 1, 1, 1, "R7 blank open");
        cyc(1, 0, 0, 0, 0, "R8 back");
        // R9: all-ones pattern.
        load_word(12'hFFF, 1, 0, "R9 all ones");
        cyc(1, 0, 0, 0, 0, "R9 all ones held");
        // R1: mid-run reset.
        cyc(0, 1, 1, 1, 0, "R1 mid reset");
        cyc(1, 0, 0, 0, 0, "R1 cleared");
        cyc(1, 0, 0, 0, 0, "R1 cleared");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule